// File: doc/BRIEF.md
# Calendar Real-Time Clock with Alarms

This block keeps wall-clock time and date for a chip that runs from a fast system clock but gets its time base as a strobe. `base_tick` is a one-cycle pulse that arrives once per period of a 32.768 kHz reference. An internal divider counts these strobes into seconds. The block holds seconds, minutes, hours (24-hour), day of week, day of month, month and a two-digit year, all in BCD. February takes 29 days in leap years without help from software.

Around the counters sit these functions:
- periodic interrupt pulses every half second, every second and every minute;
- a square wave at one cycle per second;
- two alarm channels. The first can match any chosen subset of weekday, hour and minute. The second can match any chosen subset of month, day, hour and minute.

Software sets the time through a one-cycle load strobe that carries all fields at once. The load also restarts the sub-second divider.

All interrupt outputs are single-cycle pulses. They appear in the same cycle as the updated time on the field outputs.

Top module: `rtc_calendar`

## Requirements
- R1: After a synchronous active-low reset the time reads 00:00:00, weekday 0, day 01, month 01, year 00. All interrupt pulses are low and `sq1hz` is high.
- R2: After every TICKS_PER_SEC strobes of `base_tick`, the seconds advance by one in BCD, one cycle after the last strobe. Rollover works as follows:
  - seconds wrap 59 to 00 and carry into minutes;
  - minutes wrap 59 to 00 and carry into hours;
  - hours wrap 23 to 00 and carry into the day and the weekday;
  - the weekday counts 0 to 6 and then wraps to 0.
- R3: The day wraps to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months except February, carrying into the month. Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00.
- R4: February ends after day 29 when the year's value is divisible by 4 (including 00), and after day 28 otherwise.
- R5: `irq_sec` pulses for one cycle with each seconds update. `irq_half` pulses at the middle strobe (count TICKS_PER_SEC/2) and at the end of each second. `irq_min` pulses together with the update that takes the seconds from 59 to 00.
- R6: `sq1hz` is high while fewer than TICKS_PER_SEC/2 strobes of the current second have been counted, and low for the rest of the second.
- R7: A cycle with `ld_en` high writes all load fields, which are visible the next cycle, and clears the divider. The next seconds update comes after a full TICKS_PER_SEC strobes. A strobe in the load cycle is discarded and raises no interrupt.
- R8: Alarm 1 pulses `irq_alm1` with the seconds update that enters second 00, when every enabled field equals the new time. Its enable bits are bit 0 minute, bit 1 hour and bit 2 weekday.
- R9: Alarm 2 pulses `irq_alm2` under the same rule. Its enable bits are bit 0 minute, bit 1 hour, bit 2 day and bit 3 month.
- R10: An alarm with no enable bits set fires at every minute boundary. A load never fires an alarm, even when the loaded time matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_tick | input | 1 | One strobe per reference period |
| ld_en | input | 1 | Load strobe for a new time |
| ld_sec | input | 8 | Seconds to load, BCD |
| ld_min | input | 8 | Minutes to load, BCD |
| ld_hour | input | 8 | Hours to load, BCD 00-23 |
| ld_wday | input | 3 | Weekday to load, 0-6 |
| ld_day | input | 8 | Day to load, BCD |
| ld_mon | input | 8 | Month to load, BCD |
| ld_year | input | 8 | Year to load, BCD |
| al1_en | input | 3 | Alarm 1 enables: minute, hour, weekday |
| al1_wday | input | 3 | Alarm 1 weekday |
| al1_hour | input | 8 | Alarm 1 hour, BCD |
| al1_min | input | 8 | Alarm 1 minute, BCD |
| al2_en | input | 4 | Alarm 2 enables: minute, hour, day, month |
| al2_mon | input | 8 | Alarm 2 month, BCD |
| al2_day | input | 8 | Alarm 2 day, BCD |
| al2_hour | input | 8 | Alarm 2 hour, BCD |
| al2_min | input | 8 | Alarm 2 minute, BCD |
| sec_o | output | 8 | Current seconds |
| min_o | output | 8 | Current minutes |
| hour_o | output | 8 | Current hours |
| wday_o | output | 3 | Current weekday |
| day_o | output | 8 | Current day |
| mon_o | output | 8 | Current month |
| year_o | output | 8 | Current year |
| irq_half | output | 1 | Half-second pulse |
| irq_sec | output | 1 | Second pulse |
| irq_min | output | 1 | Minute pulse |
| irq_alm1 | output | 1 | Alarm 1 pulse |
| irq_alm2 | output | 1 | Alarm 2 pulse |
| sq1hz | output | 1 | One-per-second square wave |

## Verification
The sharpest collision is a load strobe arriving in the same cycle as the divider's last strobe of a second. The bench provokes it by counting strobes after a load and then asserting both inputs together. It judges the result as follows: the loaded time must appear unchanged, with no second, half-second or alarm pulse, and the next increment must wait a full second of strobes. A second collision is an alarm match on a minute or day rollover. It is provoked by loading 59 seconds just before an alarm time, and it must raise the minute pulse and the alarm pulse in the same cycle.

// File: rtl/rtc_pkg.sv
// Shared types and BCD calendar helpers for the real-time clock.
// Assumes all stored fields are valid BCD values.
package rtc_pkg;

    typedef struct packed {
        logic [7:0] year;
        logic [7:0] mon;
        logic [7:0] day;
        logic [2:0] wday;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } rtc_time_t;

    // Index of each alarm compare field in an enable vector
    localparam int F_MIN  = 0;
    localparam int F_HOUR = 1;
    localparam int F_WDAY = 2;
    localparam int F_DAY  = 3;
    localparam int F_MON  = 4;

    // BCD increment without wrap handling (caller wraps)
    function automatic logic [7:0] bcd_next(input logic [7:0] v);
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Leap when the two-digit year's value is a multiple of four
    function automatic logic is_leap(input logic [7:0] year);
        logic [6:0] b;
        b = 7'(year[7:4]) * 7'd10 + 7'(year[3:0]);
        return (b[1:0] == 2'b00);
    endfunction

    // Last day of a month, in BCD
    function automatic logic [7:0] month_last_day(input logic [7:0] mon,
                                                  input logic [7:0] year);
        case (mon)
            8'h02:                      return is_leap(year) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
// Divides the reference strobe into seconds.
// Produces the per-second and half-second strobes and the square wave.
// Assumes TPS is even and at least 2; a clear restarts the second.
module rtc_prescaler #(
    parameter int TPS = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic base_tick,
    input  logic clear,
    output logic sec_tick,
    output logic half_tick,
    output logic sq_out
);
    localparam int CW = (TPS > 2) ? $clog2(TPS) : 1;
    localparam logic [CW-1:0] LAST    = CW'(TPS - 1);
    localparam logic [CW-1:0] HALF    = CW'(TPS / 2);
    localparam logic [CW-1:0] HALF_M1 = CW'(TPS / 2 - 1);

    logic [CW-1:0] cnt;

    // Strobe counter, restarted by reset or clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (base_tick)
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    // Strobes for the second and half second, suppressed by a clear
    always_comb begin
        sec_tick  = base_tick && !clear && (cnt == LAST);
        half_tick = base_tick && !clear && ((cnt == LAST) || (cnt == HALF_M1));
        sq_out    = (cnt < HALF);
    end

    // R6: square wave falls after the middle strobe
    p_sq_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (base_tick && !clear && cnt == HALF_M1) |=> !sq_out);

    // R7: a clear restarts the second with the wave high
    p_clear_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (sq_out && cnt == '0));

endmodule

// File: rtl/rtc_timekeeper.sv
// Holds the BCD calendar and computes its one-second successor.
// Assumes loaded values are valid BCD within range; a load wins over a tick.
module rtc_timekeeper
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sec_tick,
    input  logic      ld_en,
    input  rtc_time_t ld_time,
    output rtc_time_t cur,
    output rtc_time_t nxt
);
    localparam rtc_time_t RESET_TIME = '{year: 8'h00, mon: 8'h01, day: 8'h01,
                                         wday: 3'd0, hour: 8'h00, min: 8'h00,
                                         sec: 8'h00};

    // Successor time with cascaded carries
    always_comb begin
        nxt = cur;
        if (cur.sec != 8'h59) begin
            nxt.sec = bcd_next(cur.sec);
        end else begin
            nxt.sec = 8'h00;
            if (cur.min != 8'h59) begin
                nxt.min = bcd_next(cur.min);
            end else begin
                nxt.min = 8'h00;
                if (cur.hour != 8'h23) begin
                    nxt.hour = bcd_next(cur.hour);
                end else begin
                    nxt.hour = 8'h00;
                    nxt.wday = (cur.wday == 3'd6) ? 3'd0 : cur.wday + 3'd1;
                    if (cur.day != month_last_day(cur.mon, cur.year)) begin
                        nxt.day = bcd_next(cur.day);
                    end else begin
                        nxt.day = 8'h01;
                        if (cur.mon != 8'h12) begin
                            nxt.mon = bcd_next(cur.mon);
                        end else begin
                            nxt.mon  = 8'h01;
                            nxt.year = (cur.year == 8'h99) ? 8'h00 : bcd_next(cur.year);
                        end
                    end
                end
            end
        end
    end

    // Time register: reset, load, or advance
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur <= RESET_TIME;
        else if (ld_en)
            cur <= ld_time;
        else if (sec_tick)
            cur <= nxt;
    end

    // R2: time holds between ticks
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_tick && !ld_en) |=> $stable(cur));

    // R2: seconds wrap from 59 and minutes move
    p_sec_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !ld_en && cur.sec == 8'h59) |=>
            (cur.sec == 8'h00 && cur.min != $past(cur.min)));

    // R7: a load lands exactly
    p_load_exact_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (cur == $past(ld_time)));

    // R3: a day change on the last day of a month resets the day to 01
    p_month_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !ld_en && cur.sec == 8'h59 && cur.min == 8'h59 &&
         cur.hour == 8'h23 && cur.day == 8'h31) |=> (cur.day == 8'h01));

endmodule

// File: rtl/rtc_alarm_match.sv
// Compares a candidate time against one alarm's programmed fields.
// FIELD_MASK selects which compare fields this channel has; enables
// outside the mask are ignored. No enabled field means a match.
module rtc_alarm_match
    import rtc_pkg::*;
#(
    parameter logic [4:0] FIELD_MASK = 5'b00111
) (
    input  rtc_time_t  cand,
    input  logic [4:0] en,
    input  logic [7:0] a_min,
    input  logic [7:0] a_hour,
    input  logic [2:0] a_wday,
    input  logic [7:0] a_day,
    input  logic [7:0] a_mon,
    output logic       hit
);
    logic [4:0] eff;
    logic [4:0] eq;

    // Per-field equality and the masked all-match
    always_comb begin
        eff        = en & FIELD_MASK;
        eq[F_MIN]  = (cand.min  == a_min);
        eq[F_HOUR] = (cand.hour == a_hour);
        eq[F_WDAY] = (cand.wday == a_wday);
        eq[F_DAY]  = (cand.day  == a_day);
        eq[F_MON]  = (cand.mon  == a_mon);
        hit        = &(eq | ~eff);
    end

endmodule

// File: rtl/rtc_calendar.sv
// Top of the calendar clock: divider, timekeeper, two alarm matchers
// and the registered interrupt pulses. Interrupt pulses appear together
// with the time update they belong to. Assumes base_tick is one cycle wide.
module rtc_calendar
    import rtc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       base_tick,
    input  logic       ld_en,
    input  logic [7:0] ld_sec,
    input  logic [7:0] ld_min,
    input  logic [7:0] ld_hour,
    input  logic [2:0] ld_wday,
    input  logic [7:0] ld_day,
    input  logic [7:0] ld_mon,
    input  logic [7:0] ld_year,
    input  logic [2:0] al1_en,
    input  logic [2:0] al1_wday,
    input  logic [7:0] al1_hour,
    input  logic [7:0] al1_min,
    input  logic [3:0] al2_en,
    input  logic [7:0] al2_mon,
    input  logic [7:0] al2_day,
    input  logic [7:0] al2_hour,
    input  logic [7:0] al2_min,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [2:0] wday_o,
    output logic [7:0] day_o,
    output logic [7:0] mon_o,
    output logic [7:0] year_o,
    output logic       irq_half,
    output logic       irq_sec,
    output logic       irq_min,
    output logic       irq_alm1,
    output logic       irq_alm2,
    output logic       sq1hz
);
    localparam int NUM_ALARMS = 2;

    logic      sec_tick;
    logic      half_tick;
    rtc_time_t ld_time;
    rtc_time_t cur;
    rtc_time_t nxt;
    logic [4:0] al_en   [NUM_ALARMS];
    logic [7:0] al_min  [NUM_ALARMS];
    logic [7:0] al_hour [NUM_ALARMS];
    logic [2:0] al_wday [NUM_ALARMS];
    logic [7:0] al_day  [NUM_ALARMS];
    logic [7:0] al_mon  [NUM_ALARMS];
    logic [NUM_ALARMS-1:0] al_hit;
    logic [NUM_ALARMS-1:0] al_irq;

    // Gather the load fields into one time word
    always_comb begin
        ld_time = '{year: ld_year, mon: ld_mon, day: ld_day, wday: ld_wday,
                    hour: ld_hour, min: ld_min, sec: ld_sec};
    end

    // Map each channel's enables onto the common field positions
    always_comb begin
        al_en[0]   = {2'b00, al1_en};
        al_min[0]  = al1_min;
        al_hour[0] = al1_hour;
        al_wday[0] = al1_wday;
        al_day[0]  = 8'h00;
        al_mon[0]  = 8'h00;
        al_en[1]   = {al2_en[3], al2_en[2], 1'b0, al2_en[1:0]};
        al_min[1]  = al2_min;
        al_hour[1] = al2_hour;
        al_wday[1] = 3'd0;
        al_day[1]  = al2_day;
        al_mon[1]  = al2_mon;
    end

    rtc_prescaler #(.TPS(TICKS_PER_SEC)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_tick (base_tick),
        .clear     (ld_en),
        .sec_tick  (sec_tick),
        .half_tick (half_tick),
        .sq_out    (sq1hz)
    );

    rtc_timekeeper u_keep (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_tick (sec_tick),
        .ld_en    (ld_en),
        .ld_time  (ld_time),
        .cur      (cur),
        .nxt      (nxt)
    );

    // One matcher per alarm; the mask picks the channel's field set
    for (genvar g = 0; g < NUM_ALARMS; g++) begin : g_alarm
        localparam logic [4:0] MASK = (g == 0) ? 5'b00111 : 5'b11011;
        rtc_alarm_match #(.FIELD_MASK(MASK)) u_match (
            .cand   (nxt),
            .en     (al_en[g]),
            .a_min  (al_min[g]),
            .a_hour (al_hour[g]),
            .a_wday (al_wday[g]),
            .a_day  (al_day[g]),
            .a_mon  (al_mon[g]),
            .hit    (al_hit[g])
        );
    end

    // Interrupt pulses registered alongside the time update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_half <= 1'b0;
            irq_sec  <= 1'b0;
            irq_min  <= 1'b0;
            al_irq   <= '0;
        end else begin
            irq_half <= half_tick;
            irq_sec  <= sec_tick;
            irq_min  <= sec_tick && (cur.sec == 8'h59);
            for (int i = 0; i < NUM_ALARMS; i++)
                al_irq[i] <= sec_tick && (nxt.sec == 8'h00) && al_hit[i];
        end
    end

    // Drive the field outputs
    always_comb begin
        sec_o    = cur.sec;
        min_o    = cur.min;
        hour_o   = cur.hour;
        wday_o   = cur.wday;
        day_o    = cur.day;
        mon_o    = cur.mon;
        year_o   = cur.year;
        irq_alm1 = al_irq[0];
        irq_alm2 = al_irq[1];
    end

    // R5: the minute pulse comes only with a second pulse at second 00
    p_min_with_sec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_min |-> (irq_sec && sec_o == 8'h00));

    // R8: alarm 1 fires only at second 00
    p_alm1_at_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_alm1 |-> (irq_sec && sec_o == 8'h00));

    // R9: alarm 2 fires only at second 00
    p_alm2_at_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_alm2 |-> (irq_sec && sec_o == 8'h00));

    // R10: a load raises no alarm or second pulse
    p_no_alarm_on_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (!irq_alm1 && !irq_alm2 && !irq_sec));

endmodule

// File: tb/rtc_calendar_bench.sv
// Self-checking bench: a cycle model computed from the requirements,
// random strobes and loads from a fixed seed, and directed calendar corners.
module rtc_calendar_bench;
    localparam int TPS  = 4;
    localparam int HALF = TPS / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic base_tick = 1'b0;
    logic ld_en = 1'b0;
    logic [7:0] ld_sec = 0, ld_min = 0, ld_hour = 0, ld_day = 8'h01, ld_mon = 8'h01, ld_year = 0;
    logic [2:0] ld_wday = 0;
    logic [2:0] al1_en = 0, al1_wday = 0;
    logic [7:0] al1_hour = 0, al1_min = 0;
    logic [3:0] al2_en = 0;
    logic [7:0] al2_mon = 0, al2_day = 0, al2_hour = 0, al2_min = 0;
    logic [7:0] sec_o, min_o, hour_o, day_o, mon_o, year_o;
    logic [2:0] wday_o;
    logic irq_half, irq_sec, irq_min, irq_alm1, irq_alm2, sq1hz;

    int checks = 0;
    int errors = 0;

    // model state
    int m_sec, m_min, m_hour, m_wday, m_day, m_mon, m_year, m_cnt;
    bit e_half, e_sec, e_min, e_a1, e_a2;
    bit seen_a1, seen_a2;

    always #4 clk = ~clk;

    rtc_calendar #(.TICKS_PER_SEC(TPS)) u_rtc_calendar (
        .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .ld_en(ld_en),
        .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour), .ld_wday(ld_wday),
        .ld_day(ld_day), .ld_mon(ld_mon), .ld_year(ld_year),
        .al1_en(al1_en), .al1_wday(al1_wday), .al1_hour(al1_hour), .al1_min(al1_min),
        .al2_en(al2_en), .al2_mon(al2_mon), .al2_day(al2_day), .al2_hour(al2_hour),
        .al2_min(al2_min),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
        .day_o(day_o), .mon_o(mon_o), .year_o(year_o),
        .irq_half(irq_half), .irq_sec(irq_sec), .irq_min(irq_min),
        .irq_alm1(irq_alm1), .irq_alm2(irq_alm2), .sq1hz(sq1hz)
    );

    function automatic int tobin(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] tobcd(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int days_of(input int mon, input int year);
        if (mon == 2) return (year % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic logic [55:0] model_word();
        return {tobcd(m_year), tobcd(m_mon), tobcd(m_day), 5'(m_wday),
                tobcd(m_hour), tobcd(m_min), tobcd(m_sec)};
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [55:0] act, input logic [55:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // advance the model by one second
    task automatic model_advance();
        m_sec++;
        if (m_sec == 60) begin
            m_sec = 0; e_min = 1; m_min++;
            if (m_min == 60) begin
                m_min = 0; m_hour++;
                if (m_hour == 24) begin
                    m_hour = 0;
                    m_wday = (m_wday + 1) % 7;
                    m_day++;
                    if (m_day > days_of(m_mon, m_year)) begin
                        m_day = 1; m_mon++;
                        if (m_mon == 13) begin
                            m_mon = 1;
                            m_year = (m_year + 1) % 100;
                        end
                    end
                end
            end
        end
        if (m_sec == 0) begin
            e_a1 = (!al1_en[0] || tobin(al1_min) == m_min) &&
                   (!al1_en[1] || tobin(al1_hour) == m_hour) &&
                   (!al1_en[2] || int'(al1_wday) == m_wday);
            e_a2 = (!al2_en[0] || tobin(al2_min) == m_min) &&
                   (!al2_en[1] || tobin(al2_hour) == m_hour) &&
                   (!al2_en[2] || tobin(al2_day) == m_day) &&
                   (!al2_en[3] || tobin(al2_mon) == m_mon);
        end
    endtask

    // one clock with the given strobes, then compare everything
    task automatic step(input bit tk, input bit ld);
        base_tick = tk;
        ld_en = ld;
        e_half = 0; e_sec = 0; e_min = 0; e_a1 = 0; e_a2 = 0;
        if (ld) begin
            m_sec = tobin(ld_sec); m_min = tobin(ld_min); m_hour = tobin(ld_hour);
            m_wday = int'(ld_wday); m_day = tobin(ld_day); m_mon = tobin(ld_mon);
            m_year = tobin(ld_year); m_cnt = 0;
        end else if (tk) begin
            if (m_cnt == HALF - 1) e_half = 1;
            if (m_cnt == TPS - 1) begin
                e_half = 1; e_sec = 1; m_cnt = 0;
                model_advance();
            end else begin
                m_cnt++;
            end
        end
        @(posedge clk);
        @(negedge clk);
        base_tick = 0;
        ld_en = 0;
        chk("R2", "time", {sec_o == sec_o ? year_o : 8'h00, mon_o, day_o, 5'(wday_o),
                           hour_o, min_o, sec_o}, model_word());
        chk("R5", "irq half/sec/min", 56'({irq_half, irq_sec, irq_min}),
            56'({e_half, e_sec, e_min}));
        chk("R6", "sq1hz", 56'(sq1hz), 56'(m_cnt < HALF));
        chk("R8", "irq_alm1", 56'(irq_alm1), 56'(e_a1));
        chk("R9", "irq_alm2", 56'(irq_alm2), 56'(e_a2));
        seen_a1 |= irq_alm1;
        seen_a2 |= irq_alm2;
    endtask

    task automatic load(input int s, input int mi, input int h, input int wd,
                        input int d, input int mo, input int y);
        ld_sec = tobcd(s); ld_min = tobcd(mi); ld_hour = tobcd(h);
        ld_wday = 3'(wd); ld_day = tobcd(d); ld_mon = tobcd(mo); ld_year = tobcd(y);
        step(0, 1);
    endtask

    task automatic run_secs(input int n);
        repeat (n * TPS) step(1, 0);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_sec = 0; m_min = 0; m_hour = 0; m_wday = 0; m_day = 1; m_mon = 1;
        m_year = 0; m_cnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1", "reset time", {year_o, mon_o, day_o, 5'(wday_o), hour_o, min_o, sec_o},
            {8'h00, 8'h01, 8'h01, 5'd0, 8'h00, 8'h00, 8'h00});
        chk("R1", "reset pulses/sq", 56'({irq_half, irq_sec, irq_min, irq_alm1, irq_alm2, sq1hz}),
            56'(6'b000001));

        // random strobes from reset, through a minute rollover
        for (int i = 0; i < 500; i++) step(($urandom % 3) != 0, 0);

        // R4 leap February, weekday wrap 6 -> 0
        load(59, 59, 23, 6, 28, 2, 24);
        run_secs(1);
        chk("R4", "leap feb 29", 56'({day_o, mon_o, 5'(wday_o)}), 56'({8'h29, 8'h02, 5'd0}));
        load(59, 59, 23, 1, 29, 2, 24);
        run_secs(1);
        chk("R3", "after feb 29", 56'({day_o, mon_o}), 56'({8'h01, 8'h03}));
        load(59, 59, 23, 1, 28, 2, 23);
        run_secs(1);
        chk("R4", "common feb", 56'({day_o, mon_o}), 56'({8'h01, 8'h03}));
        load(59, 59, 23, 1, 28, 2, 0);
        run_secs(1);
        chk("R4", "year 00 leap", 56'({day_o, mon_o}), 56'({8'h29, 8'h02}));
        load(59, 59, 23, 2, 30, 4, 50);
        run_secs(1);
        chk("R3", "30-day month", 56'({day_o, mon_o}), 56'({8'h01, 8'h05}));
        load(59, 59, 23, 2, 30, 1, 50);
        run_secs(1);
        chk("R3", "jan 31 exists", 56'({day_o, mon_o}), 56'({8'h31, 8'h01}));
        load(59, 59, 23, 3, 31, 12, 99);
        run_secs(1);
        chk("R3", "year wrap", 56'({year_o, mon_o, day_o}), 56'({8'h00, 8'h01, 8'h01}));

        // R7 load collides with the last strobe of a second
        load(10, 0, 0, 0, 1, 1, 0);
        repeat (TPS - 1) step(1, 0);
        ld_sec = 8'h20;
        step(1, 1);
        chk("R7", "load wins", 56'({sec_o, irq_sec, irq_half}), 56'({8'h20, 1'b0, 1'b0}));
        repeat (TPS - 1) step(1, 0);
        chk("R7", "no early advance", 56'(sec_o), 56'(8'h20));
        step(1, 0);
        chk("R7", "advance after full second", 56'(sec_o), 56'(8'h21));

        // R8 alarm 1 on weekday/hour/minute, with minute rollover
        al1_en = 3'b111; al1_wday = 3; al1_hour = 8'h07; al1_min = 8'h30;
        seen_a1 = 0;
        load(59, 29, 7, 3, 5, 6, 30);
        run_secs(1);
        chk("R8", "alarm1 fires", 56'(seen_a1), 56'(1));
        seen_a1 = 0;
        load(59, 29, 7, 4, 5, 6, 30);
        run_secs(1);
        chk("R8", "alarm1 weekday mismatch", 56'(seen_a1), 56'(0));
        al1_en = 3'b011; seen_a1 = 0;
        load(59, 29, 7, 4, 5, 6, 30);
        run_secs(1);
        chk("R8", "alarm1 weekday disabled", 56'(seen_a1), 56'(1));

        // R9 alarm 2 on month/day/hour/minute, on an hour rollover
        al1_en = 3'b000; al1_wday = 0; al1_min = 8'h45; al1_hour = 8'h02;
        al1_en = 3'b011;
        al2_en = 4'b1111; al2_mon = 8'h12; al2_day = 8'h25; al2_hour = 8'h08; al2_min = 8'h00;
        seen_a2 = 0;
        load(59, 59, 7, 5, 25, 12, 41);
        run_secs(1);
        chk("R9", "alarm2 fires", 56'(seen_a2), 56'(1));
        seen_a2 = 0;
        load(59, 59, 7, 5, 24, 12, 41);
        run_secs(1);
        chk("R9", "alarm2 day mismatch", 56'(seen_a2), 56'(0));

        // R10 no enables -> every minute; load never fires
        al1_en = 0; al2_en = 0; seen_a1 = 0; seen_a2 = 0;
        load(0, 0, 0, 0, 1, 1, 0);
        chk("R10", "no alarm on load", 56'({seen_a1, seen_a2}), 56'(0));
        load(58, 10, 3, 0, 1, 1, 0);
        run_secs(2);
        chk("R10", "wildcard alarm each minute", 56'({seen_a1, seen_a2}), 56'(2'b11));

        // random valid loads, near-match alarms, random strobes
        for (int k = 0; k < 30; k++) begin
            int s, mi, h, mo, y, d;
            s = 55 + $urandom % 5; mi = $urandom % 60; h = $urandom % 24;
            mo = 1 + $urandom % 12; y = $urandom % 100;
            d = 1 + $urandom % days_of(mo, y);
            al1_en = 3'($urandom); al1_min = tobcd((mi + 1) % 60); al1_hour = tobcd(h);
            al1_wday = 3'($urandom % 7);
            al2_en = 4'($urandom); al2_min = tobcd((mi + 1) % 60); al2_hour = tobcd(h);
            al2_day = tobcd(d); al2_mon = tobcd(mo);
            load(s, mi, h, $urandom % 7, d, mo, y);
            for (int i = 0; i < 60; i++) step(($urandom % 4) != 0, ($urandom % 97) == 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule